// File: doc/BRIEF.md
# Windowed Sub-sampling Read-out Sequencer

This block walks a Bayer-patterned pixel array and emits, one per clock, the column and row of each pixel to be read out, together with a pixel-valid strobe, a line-start strobe and a frame-start strobe. A rectangular region of interest is chosen by a start column, a start row, a width and a height, and may sit anywhere in the array. A region that runs past the array edge is cut back at that edge.

Three density settings are offered: every pixel, one in two, or one in four, in both directions. To keep the colour phase of the 2x2 Bayer cell, kept pixels come in adjacent pairs, and whole pairs are skipped between them. Read order is programmable. Columns may run from the left or the right edge of the region. Rows may run from the bottom (the default, giving a lower-left origin) or from the top. A smaller region read at a denser setting gives the same output size as a larger region read sparser, which yields 2x and 4x digital zoom.

Settings are sampled only at the clock edge that begins a frame, so each frame is read with a single coherent configuration. Frames follow each other back to back with no idle cycles.

Top module: `ws_window_scan`

## Requirements
- R1: While rst_n is low, pix_valid, line_start and frame_start are low; at the first rising edge with rst_n high the settings are sampled and the first pixel of a frame is presented, with frame_start high, in the cycle after that edge.
- R2: The effective start column is cfg_x0 when cfg_x0 < COLS and COLS-1 otherwise; a width of zero counts as one; the effective width is the smaller of that and COLS minus the effective start. Rows follow the same rule with cfg_y0, cfg_height and ROWS. Every emitted coordinate lies inside the effective region.
- R3: cfg_sub selects density per axis, counting the offset from the region corner where the scan starts: 0 keeps every offset; 1 keeps offsets whose value mod 4 is 0 or 1; 2 and 3 keep offsets whose value mod 8 is 0 or 1. Kept offsets therefore always come in adjacent pairs.
- R4: With cfg_mirror = 0 a line starts at the left (lowest) column of the region and the column rises; with cfg_mirror = 1 it starts at the right (highest) column and falls.
- R5: Row 0 is the top row of the array. With cfg_top_first = 0 the first line is the bottom (highest) row of the region and rows fall line by line; with cfg_top_first = 1 the first line is the top row and rows rise.
- R6: After reset one kept pixel is presented per clock with pix_valid high in every cycle; line_start is high exactly on the first pixel of each line, frame_start exactly on the first pixel of a frame (together with line_start), pix_row is constant within a line, and the next frame's first pixel follows the last pixel of a frame in the next cycle.
- R7: Setting changes made during a frame do not affect that frame; they take effect from the next frame start.
- R8: With COLS and ROWS multiples of 8, the full array at cfg_sub = 2, a half-size region at cfg_sub = 1 and a quarter-size region at cfg_sub = 0 give the same number of pixels per line and lines per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_x0 | input | $clog2(COLS) | Region start column |
| cfg_width | input | $clog2(COLS+1) | Region width in columns |
| cfg_y0 | input | $clog2(ROWS) | Region start row (row 0 at top) |
| cfg_height | input | $clog2(ROWS+1) | Region height in rows |
| cfg_sub | input | 2 | Density: 0 full, 1 half, 2 or 3 quarter |
| cfg_mirror | input | 1 | 1 = columns run from the right edge |
| cfg_top_first | input | 1 | 1 = rows run from the top edge, 0 = from the bottom |
| pix_valid | output | 1 | A pixel coordinate is presented |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |
| pix_col | output | $clog2(COLS) | Column of the presented pixel |
| pix_row | output | $clog2(ROWS) | Row of the presented pixel |

## Verification
The bench builds the block with COLS = 24 and ROWS = 16, so a whole frame lasts at most 384 cycles and every density, mirror and origin setting can be swept over a grid of regions. Because 24 is not a power of two, the 5-bit start-column field can name columns beyond the array, which brings start clamping within reach alongside width clipping. Both sizes are multiples of 8, so the three zoom pairings of R8 divide exactly and can be compared at the ports.

// File: rtl/ws_pkg.sv
package ws_pkg;

   typedef enum logic [1:0] {
      SUB_FULL    = 2'd0,
      SUB_HALF    = 2'd1,
      SUB_QUARTER = 2'd2,
      SUB_QTR_ALT = 2'd3
   } sub_mode_e;

   // Distance to the next kept offset. Pairs are kept whole, so an even
   // offset always steps by one; an odd offset jumps over the skipped pairs.
   function automatic logic [3:0] pair_stride(sub_mode_e mode, logic odd);
      logic [3:0] s;
      if (!odd) begin
         s = 4'd1;
      end else begin
         case (mode)
            SUB_FULL: s = 4'd1;
            SUB_HALF: s = 4'd3;
            default:  s = 4'd7;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/ws_clip.sv
module ws_clip #(
   parameter int N = 644,
   localparam int SW = $clog2(N),
   localparam int LW = $clog2(N + 1)
) (
   input  logic [SW-1:0] start_i,
   input  logic [LW-1:0] len_i,
   output logic [SW-1:0] start_o,
   output logic [LW-1:0] len_o
);

   localparam logic [LW:0]   EXT  = (LW+1)'(N);
   localparam logic [SW-1:0] LAST = SW'(N - 1);

   logic [LW:0] room;
   logic [LW:0] len_w;

   always_comb begin
      start_o = ((LW+1)'(start_i) >= EXT) ? LAST : start_i;
      room    = EXT - (LW+1)'(start_o);
      len_w   = (len_i == '0) ? (LW+1)'(1) : (LW+1)'(len_i);
      len_o   = LW'((len_w > room) ? room : len_w);
   end

endmodule

// File: rtl/ws_axis.sv
module ws_axis
   import ws_pkg::*;
#(
   parameter int N = 644,
   localparam int SW = $clog2(N),
   localparam int LW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [SW-1:0] cfg_start,
   input  logic [LW-1:0] cfg_len,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_rev,
   output logic [SW-1:0] coord,
   output logic          last,
   output logic          first
);

   generate
      if (N < 8) begin : g_axis_too_small
         $error("ws_axis: extent N must be at least 8");
      end
   endgenerate

   logic [SW-1:0] s_new;
   logic [LW-1:0] l_new;

   ws_clip #(.N(N)) u_clip (
      .start_i (cfg_start),
      .len_i   (cfg_len),
      .start_o (s_new),
      .len_o   (l_new)
   );

   // Shadow copy of the region, held for a whole frame
   logic [SW-1:0] s_q;
   logic [LW-1:0] l_q;
   logic [LW-1:0] off_q;
   sub_mode_e     mode_q;
   logic          rev_q;

   logic [LW:0] nxt;
   logic [LW:0] pos;

   always_comb begin
      nxt   = {1'b0, off_q} + (LW+1)'(pair_stride(mode_q, off_q[0]));
      last  = (nxt >= {1'b0, l_q});
      first = (off_q == '0);
      pos   = rev_q ? ({1'b0, l_q} - (LW+1)'(1) - {1'b0, off_q})
                    : {1'b0, off_q};
      coord = SW'((LW+1)'(s_q) + pos);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q    <= '0;
         l_q    <= LW'(1);
         off_q  <= '0;
         mode_q <= SUB_FULL;
         rev_q  <= 1'b0;
      end else if (load) begin
         s_q    <= s_new;
         l_q    <= l_new;
         off_q  <= '0;
         mode_q <= sub_mode_e'(cfg_mode);
         rev_q  <= cfg_rev;
      end else if (adv) begin
         off_q  <= last ? '0 : LW'(nxt);
      end
   end

   // R2: the scan offset never leaves the clipped region
   assert_offset_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      off_q < l_q);

   // R2: every coordinate lies inside the array
   assert_coord_in_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (LW+1)'(coord) < (LW+1)'(N));

   // R3: an even offset is always followed by its odd partner
   assert_pair_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !last && !off_q[0]) |=> (off_q == $past(off_q) + LW'(1)));

endmodule

// File: rtl/ws_window_scan.sv
module ws_window_scan #(
   parameter int COLS = 644,
   parameter int ROWS = 484,
   localparam int XW  = $clog2(COLS),
   localparam int XLW = $clog2(COLS + 1),
   localparam int YW  = $clog2(ROWS),
   localparam int YLW = $clog2(ROWS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [XW-1:0]  cfg_x0,
   input  logic [XLW-1:0] cfg_width,
   input  logic [YW-1:0]  cfg_y0,
   input  logic [YLW-1:0] cfg_height,
   input  logic [1:0]     cfg_sub,
   input  logic           cfg_mirror,
   input  logic           cfg_top_first,
   output logic           pix_valid,
   output logic           line_start,
   output logic           frame_start,
   output logic [XW-1:0]  pix_col,
   output logic [YW-1:0]  pix_row
);

   generate
      if (COLS < 8 || ROWS < 8) begin : g_array_too_small
         $error("ws_window_scan: array must be at least 8 x 8");
      end
   endgenerate

   logic active;
   logic load;
   logic c_last, c_first;
   logic r_last, r_first;

   // A frame boundary reloads both axes; it wins over advancing
   always_comb begin
      load = !active || (c_last && r_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) active <= 1'b0;
      else        active <= 1'b1;
   end

   ws_axis #(.N(COLS)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .adv       (active),
      .cfg_start (cfg_x0),
      .cfg_len   (cfg_width),
      .cfg_mode  (cfg_sub),
      .cfg_rev   (cfg_mirror),
      .coord     (pix_col),
      .last      (c_last),
      .first     (c_first)
   );

   ws_axis #(.N(ROWS)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .adv       (active && c_last),
      .cfg_start (cfg_y0),
      .cfg_len   (cfg_height),
      .cfg_mode  (cfg_sub),
      .cfg_rev   (!cfg_top_first),
      .coord     (pix_row),
      .last      (r_last),
      .first     (r_first)
   );

   always_comb begin
      pix_valid   = active;
      line_start  = active && c_first;
      frame_start = active && c_first && r_first;
   end

   // R6: frame start always coincides with a line start
   assert_frame_is_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);

   // R6: the row does not change inside a line
   assert_row_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !line_start) |-> (pix_row == $past(pix_row)));

   // R6: the last pixel of a frame is followed at once by a new frame
   assert_frame_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && c_last && r_last) |=> frame_start);

   // R6: the pixel stream never pauses once running
   assert_stream_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> pix_valid);

endmodule

// File: tb/tb_ws_window_scan.sv
`timescale 1ns/1ps
module tb_ws_window_scan;

   localparam int COLS = 24;
   localparam int ROWS = 16;
   localparam int XW   = $clog2(COLS);
   localparam int XLW  = $clog2(COLS + 1);
   localparam int YW   = $clog2(ROWS);
   localparam int YLW  = $clog2(ROWS + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [XW-1:0]  cfg_x0 = '0;
   logic [XLW-1:0] cfg_width = '0;
   logic [YW-1:0]  cfg_y0 = '0;
   logic [YLW-1:0] cfg_height = '0;
   logic [1:0]     cfg_sub = '0;
   logic           cfg_mirror = 1'b0;
   logic           cfg_top_first = 1'b0;
   logic           pix_valid, line_start, frame_start;
   logic [XW-1:0]  pix_col;
   logic [YW-1:0]  pix_row;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   ws_window_scan #(.COLS(COLS), .ROWS(ROWS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_x0(cfg_x0), .cfg_width(cfg_width),
      .cfg_y0(cfg_y0), .cfg_height(cfg_height),
      .cfg_sub(cfg_sub), .cfg_mirror(cfg_mirror), .cfg_top_first(cfg_top_first),
      .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
      .pix_col(pix_col), .pix_row(pix_row)
   );

   // ---- reference model, from the requirements ----
   function automatic int eff_start(int n, int st);
      return (st >= n) ? n - 1 : st;
   endfunction

   function automatic int eff_len(int n, int st, int ln);
      int s = eff_start(n, st);
      int l = (ln == 0) ? 1 : ln;
      return (l > n - s) ? n - s : l;
   endfunction

   function automatic bit kept(int o, int md);
      if (md == 0) return 1'b1;
      if (md == 1) return (o % 4) < 2;
      return (o % 8) < 2;
   endfunction

   function automatic int axis_count(int n, int st, int ln, int md);
      int cnt = 0;
      for (int o = 0; o < eff_len(n, st, ln); o++) if (kept(o, md)) cnt++;
      return cnt;
   endfunction

   function automatic int axis_coord(int n, int st, int ln, int md, bit rv, int k);
      int s = eff_start(n, st);
      int l = eff_len(n, st, ln);
      int idx = 0;
      for (int o = 0; o < l; o++) begin
         if (kept(o, md)) begin
            if (idx == k) return rv ? s + l - 1 - o : s + o;
            idx++;
         end
      end
      return -1;
   endfunction

   task automatic drive(int x0, int w, int y0, int h, int md, bit mir, bit top);
      cfg_x0 = XW'(x0);  cfg_width = XLW'(w);
      cfg_y0 = YW'(y0);  cfg_height = YLW'(h);
      cfg_sub = 2'(md);  cfg_mirror = mir; cfg_top_first = top;
   endtask

   // Drives a setting, waits for the frame that uses it and checks every pixel.
   task automatic check_frame(int x0, int w, int y0, int h, int md, bit mir, bit top,
                              bit disturb, string tag, output bit ok,
                              output int nc, output int nr);
      ok = 1'b1;
      drive(x0, w, y0, h, md, mir, top);
      nc = axis_count(COLS, x0, w, md);
      nr = axis_count(ROWS, y0, h, md);
      do @(negedge clk); while (frame_start !== 1'b1);
      for (int r = 0; r < nr; r++) begin
         for (int c = 0; c < nc; c++) begin
            int ec, er;
            bit els, efs;
            if (!(r == 0 && c == 0)) @(negedge clk);
            if (disturb && r == 0 && c == 2) drive(10, 3, 4, 2, 0, !mir, !top);
            ec  = axis_coord(COLS, x0, w, md, mir, c);
            er  = axis_coord(ROWS, y0, h, md, !top, r);
            els = (c == 0);
            efs = (c == 0 && r == 0);
            checks++;
            if (pix_valid !== 1'b1 || line_start !== els || frame_start !== efs ||
                int'(pix_col) != ec || int'(pix_row) != er) begin
               failures++;
               ok = 1'b0;
               $display("FAIL %s line%0d px%0d: valid=%0b ls=%0b fs=%0b col=%0d row=%0d expected valid=1 ls=%0b fs=%0b col=%0d row=%0d",
                        tag, r, c, pix_valid, line_start, frame_start, pix_col, pix_row,
                        els, efs, ec, er);
            end
         end
      end
      @(negedge clk);
      checks++;
      if (frame_start !== 1'b1) begin
         failures++;
         ok = 1'b0;
         $display("FAIL R6 frame wrap (%s): frame_start=%0b expected 1", tag, frame_start);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int xs[5] = '{0, 5, 17, 23, 30};
      int ws[6] = '{0, 1, 3, 13, 24, 31};
      int ys[3] = '{0, 7, 15};
      int hs[5] = '{0, 2, 9, 16, 31};
      bit ok;
      int nc, nr;

      // R1: outputs quiet during reset
      drive(0, 24, 0, 16, 0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         checks++;
         if (pix_valid !== 1'b0 || line_start !== 1'b0 || frame_start !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: valid=%0b ls=%0b fs=%0b expected 0 0 0",
                     pix_valid, line_start, frame_start);
         end
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1, R5: first pixel after reset is the lower-left corner
      checks++;
      if (pix_valid !== 1'b1 || frame_start !== 1'b1 || line_start !== 1'b1 ||
          pix_col != 0 || pix_row != YW'(ROWS - 1)) begin
         failures++;
         $display("FAIL R1 first pixel: valid=%0b fs=%0b ls=%0b col=%0d row=%0d expected 1 1 1 col=0 row=%0d",
                  pix_valid, frame_start, line_start, pix_col, pix_row, ROWS - 1);
      end

      // R2 R3 R4: column sweep
      foreach (xs[xi]) foreach (ws[wi])
         for (int md = 0; md < 4; md++)
            for (int m = 0; m < 2; m++)
               check_frame(xs[xi], ws[wi], 3, 5, md, m[0], 1'b0, 1'b0,
                           "R2 R3 R4 columns", ok, nc, nr);

      // R2 R3 R5: row sweep
      foreach (ys[yi]) foreach (hs[hi])
         for (int md = 0; md < 4; md++)
            for (int t = 0; t < 2; t++)
               check_frame(2, 7, ys[yi], hs[hi], md, 1'b0, t[0], 1'b0,
                           "R2 R3 R5 rows", ok, nc, nr);

      // R7: settings changed mid-frame leave the running frame alone
      check_frame(1, 9, 1, 9, 1, 1'b1, 1'b0, 1'b1, "R7 mid-frame change", ok, nc, nr);
      check_frame(10, 3, 4, 2, 0, 1'b0, 1'b1, 1'b0, "R7 next frame", ok, nc, nr);

      // R8: three zoom pairings give the same output size
      check_frame(0, 24, 0, 16, 2, 1'b0, 1'b0, 1'b0, "R8 full array quarter", ok, nc, nr);
      checks++;
      if (!ok || nc != 6 || nr != 4) begin
         failures++;
         $display("FAIL R8 quarter: ok=%0b size=%0dx%0d expected ok=1 size=6x4", ok, nc, nr);
      end
      check_frame(6, 12, 4, 8, 1, 1'b0, 1'b0, 1'b0, "R8 half region half", ok, nc, nr);
      checks++;
      if (!ok || nc != 6 || nr != 4) begin
         failures++;
         $display("FAIL R8 half: ok=%0b size=%0dx%0d expected ok=1 size=6x4", ok, nc, nr);
      end
      check_frame(9, 6, 6, 4, 0, 1'b1, 1'b1, 1'b0, "R8 quarter region full", ok, nc, nr);
      checks++;
      if (!ok || nc != 6 || nr != 4) begin
         failures++;
         $display("FAIL R8 full: ok=%0b size=%0dx%0d expected ok=1 size=6x4", ok, nc, nr);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule